// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Host Controller

This block is the host side of the serial link to a 24-bit sigma-delta converter. It drives a transmit-frame strobe, a receive-frame strobe, a register-select line, a serial clock and the outgoing data, and it samples the returning data and the converter's ready flag. A host issues one command at a time. A command either writes a 24-bit word into the control or calibration registers, reads the conversion result once the converter reports ready, or reads the control or calibration registers with no regard to ready. The host can also request that result reads repeat on every fresh ready event until it sends a stop.

The word at the host port is three bytes wide. When the host works least-significant-bit first, the bits inside each byte are mirrored on their own and the byte positions are kept. The serial clock comes from a divider the host programs. Outgoing bits change on the falling serial-clock edge, and incoming bits are taken on the rising edge.

The controller is a single state machine with six states. `IDLE` accepts a command: result reads go to `WAIT_RDY` and the other commands go to `FRAME_ON`. `WAIT_RDY` moves to `FRAME_ON` when ready is low, or to `IDLE` on a stop. `FRAME_ON` asserts a frame for one half period and then enters `SHIFT`. `SHIFT` runs 24 clock pulses and then enters `FRAME_OFF`. `FRAME_OFF` holds the frame for one more half period and pulses done. It then returns to `IDLE`, or to `ARM` when continuous reading is on. `ARM` waits for ready to go high again and then moves to `WAIT_RDY`. A stop, or continuous reading that has been switched off, sends `ARM` to `IDLE`.

Top module: `adc_serial_host`

## Requirements
- R1: Each frame carries exactly 24 bits, and the most significant bit is first in both directions. `rdata` is the received bits in arrival order, with the first bit at bit 23.
- R2: Command op 0 is a write. It drops `txfrm_n` and holds `regsel` at `cmd_addr` for the whole frame. `ser_oe` is high only during that frame, and `rxfrm_n` stays high.
- R3: Command op 2 is a register read. It drops `rxfrm_n` with `regsel` equal to `cmd_addr`, and it runs whether `conv_rdy_n` is high or low.
- R4: Command op 1 is a result read. It drives `regsel` high and does not drop `rxfrm_n` until `conv_rdy_n` has been seen low.
- R5: When `cmd_lsb_first` is 1, the bits of each byte (23:16, 15:8, 7:0) are mirrored in place. This applies to write data before sending and to read data before it appears on `rdata`. When it is 0, no bit is moved.
- R6: After reset and whenever `busy` is low, both frame strobes and `ser_clk` are high. The receive frame goes high again after every read.
- R7: Each `ser_clk` low phase lasts `cfg_div`+1 clock cycles. During a write frame, `ser_do` changes only together with a falling `ser_clk`.
- R8: `busy` rises on the cycle after a command is accepted. `done` is a one-cycle pulse at the frame's end, with the word on `rdata`, and `busy` is low on the next cycle.
- R9: A result read issued with `cmd_cont`=1 repeats after each new high-to-low change of `conv_rdy_n`. Command op 3 (stop) ends this, and after the stop no frame follows a further ready event.
- R10: `txfrm_n` and `rxfrm_n` are never low together.
- R11: A read or write command offered while `busy` is high is dropped, and no frame results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 8 | Serial-clock half period minus one, in clk cycles |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 write, 1 result read, 2 register read, 3 stop |
| cmd_addr | input | 1 | Register-select level for write and register read |
| cmd_cont | input | 1 | Repeat result reads until stop |
| cmd_lsb_first | input | 1 | Host byte order is LSB first (per-byte mirror) |
| cmd_wdata | input | 24 | Write word |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata | output | 24 | Received word, valid with done |
| conv_rdy_n | input | 1 | Converter ready, active low |
| txfrm_n | output | 1 | Transmit frame, active low |
| rxfrm_n | output | 1 | Receive frame, active low |
| regsel | output | 1 | Register-select line |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_do | output | 1 | Serial data to converter |
| ser_oe | output | 1 | Drive enable for the shared data line |
| ser_di | input | 1 | Serial data from converter |

## Verification
The bench builds the block with its default parameters, three bytes per word and an 8-bit divider, and sweeps `cfg_div` over 0 to 2. For each divider value it tries both register-select levels and both byte orders. With a divider of 0 the clock phases are one cycle long, so every edge relation between launch, sampling and the frame strobes is tested at its tightest. A behavioural converter model drives ready by hand, which makes it possible to check that result reads wait for ready, that continuous reads repeat, and that a stop ends them.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    typedef enum logic [1:0] {
        OP_WRITE   = 2'd0,
        OP_RD_DATA = 2'd1,
        OP_RD_REG  = 2'd2,
        OP_STOP    = 2'd3
    } host_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_WAIT_RDY,
        ST_FRAME_ON,
        ST_SHIFT,
        ST_FRAME_OFF
    } host_state_e;

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!en)        cnt_q <= '0;
        else if (cnt_q == div) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    assign tick = en && (cnt_q == div);
endmodule

// File: rtl/adc_byte_order.sv
module adc_byte_order #(
    parameter int BYTES = 3
) (
    input  logic               lsb_first,
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign dout[8*b+i] = lsb_first ? din[8*b+7-i] : din[8*b+i];
        end
    end
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
    import adc_host_pkg::*;
#(
    parameter int WORD_BYTES = 3,
    parameter int DIV_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DIV_W-1:0]        cfg_div,
    input  logic                    cmd_valid,
    input  logic [1:0]              cmd_op,
    input  logic                    cmd_addr,
    input  logic                    cmd_cont,
    input  logic                    cmd_lsb_first,
    input  logic [8*WORD_BYTES-1:0] cmd_wdata,
    output logic                    busy,
    output logic                    done,
    output logic [8*WORD_BYTES-1:0] rdata,
    input  logic                    conv_rdy_n,
    output logic                    txfrm_n,
    output logic                    rxfrm_n,
    output logic                    regsel,
    output logic                    ser_clk,
    output logic                    ser_do,
    output logic                    ser_oe,
    input  logic                    ser_di
);
    localparam int WORD_W = 8 * WORD_BYTES;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    host_state_e state_q, state_d;
    host_op_e    op_q;
    host_op_e    op_in;
    logic              lsb_q, cont_q, a0_q, sclk_q;
    logic [WORD_W-1:0] txsr_q, rxsr_q, tx_word;
    logic [CNT_W-1:0]  bitcnt_q;
    logic              tick, accept, stop_req, frame_act, enter_frame;

    assign op_in    = host_op_e'(cmd_op);
    assign accept   = cmd_valid && (state_q == ST_IDLE) && (op_in != OP_STOP);
    assign stop_req = cmd_valid && (op_in == OP_STOP);

    adc_sclk_div #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (frame_act),
        .div  (cfg_div),
        .tick (tick)
    );

    adc_byte_order #(.BYTES(WORD_BYTES)) u_tx_order (
        .lsb_first(cmd_lsb_first),
        .din      (cmd_wdata),
        .dout     (tx_word)
    );

    adc_byte_order #(.BYTES(WORD_BYTES)) u_rx_order (
        .lsb_first(lsb_q),
        .din      (rxsr_q),
        .dout     (rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept)
                    state_d = (op_in == OP_RD_DATA) ? ST_WAIT_RDY : ST_FRAME_ON;
            end
            ST_ARM: begin
                if (stop_req || !cont_q) state_d = ST_IDLE;
                else if (conv_rdy_n)     state_d = ST_WAIT_RDY;
            end
            ST_WAIT_RDY: begin
                if (stop_req)        state_d = ST_IDLE;
                else if (!conv_rdy_n) state_d = ST_FRAME_ON;
            end
            ST_FRAME_ON: begin
                if (tick) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (tick && !sclk_q && (bitcnt_q == LAST_BIT)) state_d = ST_FRAME_OFF;
            end
            ST_FRAME_OFF: begin
                if (tick) state_d = (cont_q && !stop_req) ? ST_ARM : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        frame_act = (state_q == ST_FRAME_ON) || (state_q == ST_SHIFT) ||
                    (state_q == ST_FRAME_OFF);
        txfrm_n   = !(frame_act && (op_q == OP_WRITE));
        rxfrm_n   = !(frame_act && (op_q != OP_WRITE));
        ser_oe    = frame_act && (op_q == OP_WRITE);
        busy      = (state_q != ST_IDLE) && (state_q != ST_ARM);
        done      = (state_q == ST_FRAME_OFF) && tick;
        regsel    = a0_q;
        ser_clk   = sclk_q;
        ser_do    = txsr_q[WORD_W-1];
    end

    assign enter_frame = (state_q != ST_FRAME_ON) && (state_d == ST_FRAME_ON);

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_WRITE;
            lsb_q    <= 1'b0;
            cont_q   <= 1'b0;
            a0_q     <= 1'b1;
            sclk_q   <= 1'b1;
            txsr_q   <= '0;
            rxsr_q   <= '0;
            bitcnt_q <= '0;
        end else begin
            if (accept) begin
                op_q   <= op_in;
                lsb_q  <= cmd_lsb_first;
                cont_q <= cmd_cont && (op_in == OP_RD_DATA);
                a0_q   <= (op_in == OP_RD_DATA) ? 1'b1 : cmd_addr;
                txsr_q <= tx_word;
            end else if (stop_req) begin
                cont_q <= 1'b0;
            end
            if (enter_frame) begin
                bitcnt_q <= '0;
                sclk_q   <= 1'b1;
            end
            if ((state_q == ST_SHIFT) && tick) begin
                if (sclk_q) begin
                    sclk_q <= 1'b0;
                    if (bitcnt_q != '0) txsr_q <= {txsr_q[WORD_W-2:0], 1'b0};
                end else begin
                    sclk_q   <= 1'b1;
                    rxsr_q   <= {rxsr_q[WORD_W-2:0], ser_di};
                    bitcnt_q <= bitcnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_serial_host_chk.sv
module adc_serial_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       txfrm_n,
    input logic       rxfrm_n,
    input logic       regsel,
    input logic       ser_clk,
    input logic       ser_do,
    input logic       conv_rdy_n,
    input logic       busy,
    input logic       done,
    input logic [1:0] op_q
);
    AST_FRAMES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!txfrm_n && !rxfrm_n)); // R10

    AST_LAUNCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!txfrm_n && $past(!txfrm_n) && !$stable(ser_do)) |-> $fell(ser_clk)); // R7

    AST_RESULT_WAITS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rxfrm_n) && (op_q == 2'd1)) |-> !$past(conv_rdy_n)); // R4

    AST_RESULT_SELECT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!rxfrm_n && (op_q == 2'd1)) |-> regsel); // R4

    AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (txfrm_n && rxfrm_n && ser_clk)); // R6

    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R8

    AST_DONE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((!txfrm_n || !rxfrm_n) && ser_clk)); // R8

    AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((!txfrm_n || !rxfrm_n) && $past(!txfrm_n || !rxfrm_n)) |-> $stable(regsel)); // R2
endmodule

bind adc_serial_host adc_serial_host_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .txfrm_n   (txfrm_n),
    .rxfrm_n   (rxfrm_n),
    .regsel    (regsel),
    .ser_clk   (ser_clk),
    .ser_do    (ser_do),
    .conv_rdy_n(conv_rdy_n),
    .busy      (busy),
    .done      (done),
    .op_q      (op_q)
);

// File: tb/adc_serial_host_tb.sv
module adc_serial_host_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_div = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic        cmd_addr = 1'b0, cmd_cont = 1'b0, cmd_lsb_first = 1'b0;
    logic [23:0] cmd_wdata = '0;
    logic        busy, done;
    logic [23:0] rdata;
    logic        conv_rdy_n = 1'b1;
    logic        txfrm_n, rxfrm_n, regsel, ser_clk, ser_do, ser_oe;
    logic        ser_di = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_serial_host u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_cont(cmd_cont),
        .cmd_lsb_first(cmd_lsb_first), .cmd_wdata(cmd_wdata), .busy(busy),
        .done(done), .rdata(rdata), .conv_rdy_n(conv_rdy_n), .txfrm_n(txfrm_n),
        .rxfrm_n(rxfrm_n), .regsel(regsel), .ser_clk(ser_clk), .ser_do(ser_do),
        .ser_oe(ser_oe), .ser_di(ser_di)
    );

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input logic [23:0] act,
                         input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] mirror(input logic [23:0] w);
        logic [23:0] r;
        for (int b = 0; b < 3; b++)
            for (int i = 0; i < 8; i++)
                r[8*b+i] = w[8*b+7-i];
        return r;
    endfunction

    // converter model
    logic [23:0] dev_word = '0;
    logic [23:0] cap = '0;
    int wr_frames = 0, rd_frames = 0, rcnt = 0, wr_bits = 0;
    logic wr_a0 = 1'b0, rd_a0 = 1'b0, rd_rdy = 1'b0;
    int lowrun = 0, last_low = 0;

    always @(negedge txfrm_n) begin
        wr_frames++;
        wr_a0 = regsel;
    end
    always @(negedge rxfrm_n) begin
        rd_frames++;
        rd_a0 = regsel;
        rd_rdy = conv_rdy_n;
        rcnt = 0;
        ser_di = dev_word[23];
    end
    always @(posedge ser_clk) begin
        if (!txfrm_n) begin
            cap = {cap[22:0], ser_do};
            wr_bits++;
        end
        if (!rxfrm_n) begin
            rcnt++;
            if (rcnt < 24) ser_di = dev_word[23-rcnt];
        end
    end
    always @(negedge clk) begin
        if (!ser_clk) lowrun++;
        else if (lowrun != 0) begin
            last_low = lowrun;
            lowrun = 0;
        end
    end

    task automatic issue(input logic [1:0] op, input logic addr, input logic cont,
                         input logic lsb, input logic [23:0] w);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
        cmd_cont = cont; cmd_lsb_first = lsb; cmd_wdata = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) check(1'b0, {req, " watchdog"}, 24'(n), 24'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int wf, rf;
        logic [23:0] w, expw;
        repeat (3) @(negedge clk);
        // R6 reset state
        check(txfrm_n && rxfrm_n && ser_clk && !busy && !done, "R6 reset",
              {19'd0, txfrm_n, rxfrm_n, ser_clk, busy, done}, 24'h1C);
        rst_n = 1'b1;
        @(negedge clk);

        for (int d = 0; d < 3; d++) begin
            for (int a = 0; a < 2; a++) begin
                for (int l = 0; l < 2; l++) begin
                    cfg_div = 8'(d);
                    w = 24'h5A3C96 ^ (24'(d) * 24'h010203) ^ (a ? 24'h800001 : 24'h0)
                        ^ (l ? 24'h0F00F0 : 24'h0);
                    expw = l ? mirror(w) : w;
                    wf = wr_frames; rf = rd_frames; wr_bits = 0;
                    issue(2'd0, a[0], 1'b0, l[0], w);
                    check(busy, "R8 busy after accept", {23'd0, busy}, 24'd1);
                    wait_done("R8");
                    @(negedge clk);
                    check(cap == expw, l ? "R5 write mirror" : "R1 write order", cap, expw);
                    check(wr_bits == 24, "R1 write bit count", 24'(wr_bits), 24'd24);
                    check(wr_a0 == a[0], "R2 write select", {23'd0, wr_a0}, 24'(a));
                    check(wr_frames == wf + 1 && rd_frames == rf, "R2 single write frame",
                          24'(rd_frames - rf), 24'd0);
                    check(last_low == d + 1, "R7 low phase", 24'(last_low), 24'(d + 1));
                    check(!busy && txfrm_n, "R8 idle after write", {23'd0, busy}, 24'd0);

                    // register read with ready held high
                    dev_word = ~w ^ 24'h3300CC;
                    expw = l ? mirror(dev_word) : dev_word;
                    conv_rdy_n = 1'b1;
                    rf = rd_frames;
                    issue(2'd2, a[0], 1'b0, l[0], 24'h0);
                    wait_done("R3");
                    check(rdata == expw, l ? "R5 read mirror" : "R1 read order", rdata, expw);
                    @(negedge clk);
                    check(rd_frames == rf + 1 && rd_rdy == 1'b1, "R3 ready ignored",
                          24'(rd_frames - rf), 24'd1);
                    check(rd_a0 == a[0], "R3 read select", {23'd0, rd_a0}, 24'(a));
                    check(rxfrm_n, "R6 receive frame released", {23'd0, rxfrm_n}, 24'd1);
                end
            end
        end

        // R4 result read waits for ready
        cfg_div = 8'd1;
        conv_rdy_n = 1'b1;
        rf = rd_frames;
        issue(2'd1, 1'b0, 1'b0, 1'b0, 24'h0);
        repeat (40) @(negedge clk);
        check(rd_frames == rf && busy, "R4 no frame before ready", 24'(rd_frames - rf), 24'd0);
        dev_word = 24'hC0FFEE;
        conv_rdy_n = 1'b0;
        wait_done("R4");
        check(rdata == 24'hC0FFEE, "R4 result word", rdata, 24'hC0FFEE);
        check(rd_a0 == 1'b1 && rd_rdy == 1'b0, "R4 select high", {23'd0, rd_a0}, 24'd1);
        @(negedge clk);
        conv_rdy_n = 1'b1;
        check(rxfrm_n && !busy, "R6 release after result", {23'd0, rxfrm_n}, 24'd1);

        // R9 continuous reads
        rf = rd_frames;
        issue(2'd1, 1'b0, 1'b1, 1'b1, 24'h0);
        for (int k = 0; k < 3; k++) begin
            dev_word = 24'h123456 + 24'(k) * 24'h111111;
            repeat (3) @(negedge clk);
            conv_rdy_n = 1'b0;
            wait_done("R9");
            check(rdata == mirror(dev_word), "R9 repeated word", rdata, mirror(dev_word));
            @(negedge clk);
            check(!busy, "R9 idle between reads", {23'd0, busy}, 24'd0);
            conv_rdy_n = 1'b1;
        end
        check(rd_frames == rf + 3, "R9 frame count", 24'(rd_frames - rf), 24'd3);
        repeat (3) @(negedge clk);
        issue(2'd3, 1'b0, 1'b0, 1'b0, 24'h0);
        conv_rdy_n = 1'b0;
        repeat (60) @(negedge clk);
        check(rd_frames == rf + 3 && !busy, "R9 stop ends repeats", 24'(rd_frames - rf), 24'd3);
        conv_rdy_n = 1'b1;

        // R11 command while busy is dropped
        cfg_div = 8'd2;
        rf = rd_frames; wf = wr_frames;
        issue(2'd0, 1'b1, 1'b0, 1'b0, 24'hA5A5A5);
        repeat (4) @(negedge clk);
        issue(2'd2, 1'b0, 1'b0, 1'b0, 24'h0);
        wait_done("R11");
        repeat (60) @(negedge clk);
        check(rd_frames == rf && wr_frames == wf + 1 && !busy, "R11 busy drop",
              24'(rd_frames - rf), 24'd0);
        check(cap == 24'hA5A5A5, "R2 write during drop", cap, 24'hA5A5A5);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule